// File: doc/BRIEF.md
# Late Branch Resolution and Next-PC Selector

This block owns the fetch program counter of a five-stage in-order pipeline and decides, every cycle, where fetch goes next. It looks at the instruction currently in the execute stage. It resolves conditional equality branches and register-indirect jump-and-link instructions there. A small adder, kept apart from the main ALU, forms the branch target from the instruction's own PC, plus one, plus its sign-extended offset.

The policy is predict-not-taken. When a branch is taken, or whenever a jump-and-link executes, the block raises clear requests for the fetch/decode and decode/execute pipeline registers. This squashes exactly the two younger instructions already fetched. A not-taken branch leaves them untouched. A stall request from the hazard logic freezes the PC unless a redirect happens in the same cycle, and the redirect wins. The block also supplies the link value, which is the jump's PC plus one, for the register write in a later stage.

Top module: `pcsel_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pc_q` equals parameter `RESET_PC` (default 0), and `flush_fd`, `flush_de` and `fetch_hold` are 0.
- R2: With no redirect and no stall, `pc_sel` is 0, `next_pc` is `pc_q + 1` modulo 2^PC_W, and `pc_q` takes that value at the next clock edge.
- R3: A valid branch (opcode 4'b0101) whose two operands are equal gives `pc_sel` 1 and `next_pc = ex_pc + 1 + sext(ex_offset)` modulo 2^PC_W. `pc_q` loads this value at the next edge.
- R4: A valid branch whose operands differ causes no flush and no redirect. `pc_sel` is 0 and fetch continues sequentially.
- R5: A valid jump-and-link (opcode 4'b0110) always gives `pc_sel` 2. When the two register indices differ, `next_pc` is the low PC_W bits of `ex_rx_val`.
- R6: For a jump-and-link whose two register indices are equal, `next_pc` is `ex_pc + 1`, not the stale register value.
- R7: `link_val` always equals `ex_pc + 1` modulo 2^PC_W.
- R8: `flush_fd` and `flush_de` are both 1 in the cycle a redirect (R3 or R5) is selected, and both 0 otherwise.
- R9: A stall request with no redirect gives `pc_sel` 3 and `fetch_hold` 1, and `pc_q` keeps its value across the edge.
- R10: A redirect and a stall request in the same cycle resolve to the redirect. `fetch_hold` is 0, the flushes are 1, and `pc_q` loads the target.
- R11: With `ex_valid` at 0, no opcode or operand value causes a flush or a redirect.
- R12: Opcodes other than 4'b0101 and 4'b0110 never redirect or flush, even with equal operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_req | input | 1 | Hazard logic asks fetch to hold |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_opcode | input | 4 | Opcode of the execute-stage instruction |
| ex_pc | input | PC_W | Address of the execute-stage instruction |
| ex_rx_idx | input | REG_W | First register index |
| ex_ry_idx | input | REG_W | Second register index |
| ex_rx_val | input | DATA_W | First register operand |
| ex_ry_val | input | DATA_W | Second register operand |
| ex_offset | input | OFF_W | Two's-complement offset field |
| pc_q | output | PC_W | Current fetch PC |
| next_pc | output | PC_W | Value the PC takes at the next edge |
| pc_sel | output | 2 | Source code: 0 sequential, 1 branch, 2 jump, 3 hold |
| flush_fd | output | 1 | Clear fetch/decode register |
| flush_de | output | 1 | Clear decode/execute register |
| fetch_hold | output | 1 | Fetch/decode register keeps its contents |
| link_val | output | PC_W | Return address for jump-and-link |

## Verification
The branch target is swept over every offset value of a narrow configuration, from several instruction addresses including ones that wrap. Each sweep runs with equal operands and again with unequal operands, which separates the taken and not-taken paths and confirms the sign extension at both ends of the range. The jump is tried over every pair of register indices, which separates the equal-index case from the register-value target. The whole opcode space is swept with valid high and again with valid low, so that a decode error on any stray opcode is caught. Stall patterns are applied alone and combined with each redirect kind to show that the redirect wins.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;
   localparam int OPC_W = 4;
   localparam logic [OPC_W-1:0] OPC_BEQ  = 4'b0101;
   localparam logic [OPC_W-1:0] OPC_JALR = 4'b0110;

   typedef enum logic [1:0] {
      SEL_SEQ  = 2'd0,
      SEL_BR   = 2'd1,
      SEL_JMP  = 2'd2,
      SEL_HOLD = 2'd3
   } sel_e;

   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_BEQ  = 2'd1,
      K_JALR = 2'd2
   } kind_e;
endpackage

// File: rtl/pcsel_decode.sv
module pcsel_decode
   import pcsel_pkg::*;
(
   input  logic             valid,
   input  logic [OPC_W-1:0] opcode,
   output kind_e            kind
);
   always_comb begin
      kind = K_NONE;
      if (valid) begin
         unique case (opcode)
            OPC_BEQ:  kind = K_BEQ;
            OPC_JALR: kind = K_JALR;
            default:  kind = K_NONE;
         endcase
      end
   end
endmodule

// File: rtl/pcsel_target.sv
module pcsel_target #(
   parameter int PC_W  = 32,
   parameter int OFF_W = 20
) (
   input  logic [PC_W-1:0]  ex_pc,
   input  logic [OFF_W-1:0] offset,
   output logic [PC_W-1:0]  ex_pc_inc,
   output logic [PC_W-1:0]  br_target
);
   logic [PC_W-1:0] off_ext;

   generate
      if (OFF_W >= PC_W) begin : g_trunc
         assign off_ext = offset[PC_W-1:0];
      end else begin : g_sext
         assign off_ext = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
      end
   endgenerate

   assign ex_pc_inc = ex_pc + {{(PC_W-1){1'b0}}, 1'b1};
   assign br_target = ex_pc_inc + off_ext;
endmodule

// File: rtl/pcsel_resolve.sv
module pcsel_resolve
   import pcsel_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int DATA_W = 32,
   parameter int REG_W  = 4
) (
   input  kind_e             kind,
   input  logic              stall_req,
   input  logic [PC_W-1:0]   pc_q,
   input  logic [PC_W-1:0]   ex_pc_inc,
   input  logic [PC_W-1:0]   br_target,
   input  logic [REG_W-1:0]  rx_idx,
   input  logic [REG_W-1:0]  ry_idx,
   input  logic [DATA_W-1:0] rx_val,
   input  logic [DATA_W-1:0] ry_val,
   output sel_e              sel,
   output logic [PC_W-1:0]   next_pc,
   output logic              redirect,
   output logic              hold
);
   logic            br_taken;
   logic            jump;
   logic [PC_W-1:0] jmp_target;

   always_comb begin
      br_taken   = (kind == K_BEQ) && (rx_val == ry_val);
      jump       = (kind == K_JALR);
      redirect   = br_taken || jump;
      hold       = stall_req && !redirect;
      jmp_target = (rx_idx == ry_idx) ? ex_pc_inc : rx_val[PC_W-1:0];
      if (jump) begin
         sel     = SEL_JMP;
         next_pc = jmp_target;
      end else if (br_taken) begin
         sel     = SEL_BR;
         next_pc = br_target;
      end else if (stall_req) begin
         sel     = SEL_HOLD;
         next_pc = pc_q;
      end else begin
         sel     = SEL_SEQ;
         next_pc = pc_q + {{(PC_W-1){1'b0}}, 1'b1};
      end
   end
endmodule

// File: rtl/pcsel_top.sv
module pcsel_top
   import pcsel_pkg::*;
#(
   parameter int          PC_W     = 32,
   parameter int          DATA_W   = 32,
   parameter int          REG_W    = 4,
   parameter int          OFF_W    = 20,
   parameter logic [31:0] RESET_PC = 32'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_req,
   input  logic              ex_valid,
   input  logic [3:0]        ex_opcode,
   input  logic [PC_W-1:0]   ex_pc,
   input  logic [REG_W-1:0]  ex_rx_idx,
   input  logic [REG_W-1:0]  ex_ry_idx,
   input  logic [DATA_W-1:0] ex_rx_val,
   input  logic [DATA_W-1:0] ex_ry_val,
   input  logic [OFF_W-1:0]  ex_offset,
   output logic [PC_W-1:0]   pc_q,
   output logic [PC_W-1:0]   next_pc,
   output logic [1:0]        pc_sel,
   output logic              flush_fd,
   output logic              flush_de,
   output logic              fetch_hold,
   output logic [PC_W-1:0]   link_val
);
   localparam logic [PC_W-1:0] PC_INIT = RESET_PC[PC_W-1:0];

   generate
      if (PC_W < 2 || PC_W > 32) begin : g_bad_pcw
         $error("PC_W must lie in 2..32");
      end
      if (DATA_W < PC_W) begin : g_bad_dw
         $error("DATA_W must be at least PC_W");
      end
      if (OFF_W < 1 || REG_W < 1) begin : g_bad_fields
         $error("OFF_W and REG_W must be positive");
      end
   endgenerate

   kind_e           kind;
   sel_e            sel;
   logic [PC_W-1:0] ex_pc_inc;
   logic [PC_W-1:0] br_target;
   logic [PC_W-1:0] nxt;
   logic            redirect;
   logic            hold;

   pcsel_decode u_dec (
      .valid  (ex_valid),
      .opcode (ex_opcode),
      .kind   (kind)
   );

   pcsel_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
      .ex_pc     (ex_pc),
      .offset    (ex_offset),
      .ex_pc_inc (ex_pc_inc),
      .br_target (br_target)
   );

   pcsel_resolve #(.PC_W(PC_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_res (
      .kind       (kind),
      .stall_req  (stall_req),
      .pc_q       (pc_q),
      .ex_pc_inc  (ex_pc_inc),
      .br_target  (br_target),
      .rx_idx     (ex_rx_idx),
      .ry_idx     (ex_ry_idx),
      .rx_val     (ex_rx_val),
      .ry_val     (ex_ry_val),
      .sel        (sel),
      .next_pc    (nxt),
      .redirect   (redirect),
      .hold       (hold)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= PC_INIT;
      else        pc_q <= nxt;
   end

   always_comb begin
      next_pc    = nxt;
      pc_sel     = sel;
      flush_fd   = rst_n && redirect;
      flush_de   = rst_n && redirect;
      fetch_hold = rst_n && hold;
      link_val   = ex_pc_inc;
   end

   // R2: sequential selection advances the PC by one
   a_r2_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_sel == SEL_SEQ) |=> (pc_q == $past(pc_q) + 1'b1));
   // R9: a hold keeps the PC
   a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_hold |=> $stable(pc_q));
   // R10: a redirect beats a stall
   a_r10_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_fd && stall_req) |-> !fetch_hold);
   // R8: both pipeline clears move together
   a_r8_flush_pair: assert property (@(posedge clk) disable iff (!rst_n)
      flush_fd == flush_de);
   // R5: a live jump always redirects and flushes
   a_r5_jalr_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && ex_opcode == OPC_JALR) |-> (flush_fd && pc_sel == SEL_JMP));
   // R11: nothing happens without a live instruction
   a_r11_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_valid |-> !flush_fd);
   // R3: a taken branch target lands in the PC
   a_r3_target_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_sel == SEL_BR) |=> (pc_q == $past(next_pc)));
   // R4: unequal operands on a branch never flush
   a_r4_nottaken_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && ex_opcode == OPC_BEQ && ex_rx_val != ex_ry_val) |-> !flush_fd);
endmodule

// File: tb/sim_pcsel_top.sv
module sim_pcsel_top;
   localparam int PW = 8;
   localparam int DW = 8;
   localparam int RW = 4;
   localparam int OW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stall_req = 1'b0;
   logic          ex_valid = 1'b0;
   logic [3:0]    ex_opcode = 4'd0;
   logic [PW-1:0] ex_pc = '0;
   logic [RW-1:0] ex_rx_idx = '0;
   logic [RW-1:0] ex_ry_idx = '0;
   logic [DW-1:0] ex_rx_val = '0;
   logic [DW-1:0] ex_ry_val = '0;
   logic [OW-1:0] ex_offset = '0;
   logic [PW-1:0] pc_q, next_pc, link_val;
   logic [1:0]    pc_sel;
   logic          flush_fd, flush_de, fetch_hold;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   pcsel_top #(.PC_W(PW), .DATA_W(DW), .REG_W(RW), .OFF_W(OW), .RESET_PC(32'd0)) u0 (
      .clk(clk), .rst_n(rst_n), .stall_req(stall_req), .ex_valid(ex_valid),
      .ex_opcode(ex_opcode), .ex_pc(ex_pc), .ex_rx_idx(ex_rx_idx), .ex_ry_idx(ex_ry_idx),
      .ex_rx_val(ex_rx_val), .ex_ry_val(ex_ry_val), .ex_offset(ex_offset),
      .pc_q(pc_q), .next_pc(next_pc), .pc_sel(pc_sel), .flush_fd(flush_fd),
      .flush_de(flush_de), .fetch_hold(fetch_hold), .link_val(link_val));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive at negedge, check combinational outputs, then check PC after edge
   task automatic step(input string req, input int exp_sel, input int exp_nxt,
                       input int exp_fl, input int exp_hold);
      #2;
      chk(req, pc_sel, exp_sel);
      chk(req, next_pc, exp_nxt);
      chk(req, flush_fd, exp_fl);
      chk(req, flush_de, exp_fl);
      chk(req, fetch_hold, exp_hold);
      @(posedge clk); #2;
      chk(req, pc_q, exp_nxt);
      @(negedge clk);
   endtask

   function automatic int sext(input int off);
      return (off >= (1 << (OW-1))) ? off - (1 << OW) : off;
   endfunction

   initial begin
      #4000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int pcs[4];
      pcs[0] = 0; pcs[1] = 37; pcs[2] = 200; pcs[3] = 255;
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", pc_q, 0);
      chk("R1", flush_fd, 0);
      chk("R1", fetch_hold, 0);
      rst_n = 1'b1;
      #2 chk("R1", pc_q, 0);
      @(negedge clk);
      // R2: sequential fetch
      for (int i = 0; i < 5; i++) step("R2", 0, (pc_q + 1) & 255, 0, 0);
      // R9: stall holds
      stall_req = 1'b1;
      for (int i = 0; i < 3; i++) step("R9", 3, pc_q, 0, 1);
      stall_req = 1'b0;
      // R3 / R4 / R7: branch sweep over every offset
      ex_valid = 1'b1; ex_opcode = 4'b0101;
      foreach (pcs[p]) begin
         for (int o = 0; o < (1 << OW); o++) begin
            ex_pc = pcs[p][PW-1:0]; ex_offset = o[OW-1:0];
            ex_rx_val = 8'd9; ex_ry_val = 8'd9;
            #1 chk("R7", link_val, (pcs[p] + 1) & 255);
            step("R3", 1, (pcs[p] + 1 + sext(o)) & 255, 1, 0);
            ex_ry_val = 8'd10;
            step("R4", 0, (pc_q + 1) & 255, 0, 0);
         end
      end
      // R5 / R6: jump over every index pair
      ex_opcode = 4'b0110; ex_pc = 8'd100;
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            ex_rx_idx = a[RW-1:0]; ex_ry_idx = b[RW-1:0];
            ex_rx_val = 8'(a * 13 + b); ex_ry_val = 8'(b);
            #1 chk("R7", link_val, 101);
            if (a == b) step("R6", 2, 101, 1, 0);
            else        step("R5", 2, (a * 13 + b) & 255, 1, 0);
         end
      end
      // R10: redirect beats stall, for both kinds
      stall_req = 1'b1;
      ex_rx_idx = 4'd3; ex_ry_idx = 4'd4; ex_rx_val = 8'd77;
      step("R10", 2, 77, 1, 0);
      ex_opcode = 4'b0101; ex_pc = 8'd20; ex_offset = 6'd5; ex_ry_val = 8'd77;
      step("R10", 1, 26, 1, 0);
      stall_req = 1'b0;
      // R12: other opcodes never redirect, R11: invalid never redirects
      for (int op = 0; op < 16; op++) begin
         ex_opcode = op[3:0]; ex_valid = 1'b1;
         ex_rx_val = 8'd5; ex_ry_val = 8'd5; ex_rx_idx = 4'd1; ex_ry_idx = 4'd2;
         if (op != 5 && op != 6) step("R12", 0, (pc_q + 1) & 255, 0, 0);
         ex_valid = 1'b0;
         step("R11", 0, (pc_q + 1) & 255, 0, 0);
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule